// File: doc/BRIEF.md
# Full-Speed USB Host Controller Register Block

This block holds the software-visible control state of a full-speed USB host controller with four root ports. Registers are reached through a 32-byte, 16-bit-wide I/O window. The window carries command, status, interrupt enable, frame number, a 32-bit frame list base split into two halves, start-of-frame timing and one status/control word per root port. Reads are combinational on the offset. A write lands on the rising clock edge where `wr_en` is high.

The block also counts frames. While the run bit is set, each `frame_tick` advances an 11-bit frame number. Transfer events from the scheduler (completion interrupt, short packet, error) and resume requests set status bits. An interrupt line is raised from those bits through the enables. Status bits clear when written with 1. The block also keeps a hidden cause record, shown on `int_cause`, that tells a completion interrupt from a short-packet one.

Single-cycle pulses tell the rest of the controller when scheduling should start, when the bus must be reset and when an individual port must be reset. Every pulse is registered and appears in the cycle after the write that causes it.

Top module: `usb_hc_regs`

## Requirements
- R1: After reset the registers read as follows: command 0x0000, status 0x0020 (halted bit 5 set), interrupt enable 0x0000, frame number 0, both base halves 0, SOF timing 0x0040. Each port word reads 0x0080, with bit 0 showing that port's `dev_attached` input. `irq`, `int_cause` and all pulses are 0.
- R2: Offsets are: 0x00 command, 0x02 status, 0x04 interrupt enable (4 bits), 0x06 frame number, 0x08 base low, 0x0A base high, 0x0C SOF timing, and 0x10 + 2·n for port n (n = 0..3). Any other offset reads 0, and a write to it changes no register.
- R3: Writing the status register clears each of bits 0 (USB interrupt), 1 (error) and 2 (resume detect) where the written value is 1. Writing 1 to bit 0 also clears the hidden cause record `int_cause`. A completion event sets bit 0 and `int_cause[0]`. A short-packet event sets bit 0 and `int_cause[1]`. An error event sets bit 1. A set in the same cycle wins over a clear.
- R4: `irq` is high exactly when any of these holds: bit 0 is set and (`int_cause[0]` and enable bit 2), or bit 0 is set and (`int_cause[1]` and enable bit 3); bit 1 and enable bit 0 are both set; bit 2 and enable bit 1 are both set. `irq` follows the registers in the same cycle as the update.
- R5: A frame number write takes effect only while status bit 5 (halted) is set. It stores the low 11 bits of the written value.
- R6: On each cycle with `frame_tick` high while command bit 0 (run) is set, the frame number increments modulo 2048.
- R7: A base-low write stores the written value with bits 11:0 forced to 0. A base-high write replaces bits 31:16. Each half reads back on its own.
- R8: The SOF timing register keeps only the low 8 bits of a write.
- R9: A command write that takes run (bit 0) from 0 to 1 gives a one-cycle `sched_start` pulse. Rewriting run as 1 gives no pulse. Halted (status bit 5) reads as the inverse of run after each command write.
- R10: A port word keeps bits 2, 9 (port reset) and 12 as written. A write taking bit 9 from 0 to 1 gives a one-cycle pulse on that port's `port_reset` bit, but only when the port's `dev_attached` is high.
- R11: A command write that takes bit 2 (global reset) from 0 to 1 gives a one-cycle `bus_reset` pulse, together with a pulse on all four `port_reset` bits.
- R12: A `resume_req` while command bit 3 (enter global suspend) is set sets command bit 4 (force global resume) and status bit 2. With bit 3 clear, the request changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current offset |
| addr | input | 5 | Byte offset inside the 32-byte window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| frame_tick | input | 1 | One pulse per completed frame |
| evt_ioc | input | 1 | Transfer completed with interrupt request |
| evt_short | input | 1 | Short packet detected |
| evt_err | input | 1 | Transfer error |
| resume_req | input | 1 | Remote resume request |
| dev_attached | input | 4 | Device present per root port |
| irq | output | 1 | Interrupt request |
| int_cause | output | 2 | Hidden cause record: bit 0 completion, bit 1 short packet |
| sched_start | output | 1 | Start-of-scheduling pulse |
| bus_reset | output | 1 | Global bus reset pulse |
| port_reset | output | 4 | Per-port reset pulses |

## Verification
Several rules are checked by assertions on every cycle. A status write of 1 to bit 0 with no event in that cycle must leave the bit and the cause record clear. A resume under suspend must set force-resume and resume-detect. A frame tick while running must advance the counter by exactly one, and a frame number write while running must leave it unchanged. A pulse must never last two cycles. A port pulse must always trace back to an attached device or a global reset, and `irq` must never be high without a status source.

Other behaviour can only be shown by the bench's scenarios: the exact read values at each offset, the field masking, the silence of unmapped offsets, the 2047-to-0 wrap, and the enable-versus-cause combinations that decide `irq`.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFF_CMD   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STS   = 5'h02;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_FRN   = 5'h06;
  localparam logic [ADDR_W-1:0] OFF_BLO   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_BHI   = 5'h0A;
  localparam logic [ADDR_W-1:0] OFF_SOF   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_PORT0 = 5'h10;

  localparam int CMD_W    = 8;
  localparam int CMD_RUN  = 0;
  localparam int CMD_GRST = 2;
  localparam int CMD_EGSM = 3;
  localparam int CMD_FGR  = 4;

  localparam int STS_INT  = 0;
  localparam int STS_ERR  = 1;
  localparam int STS_RSM  = 2;
  localparam int STS_HALT = 5;

  localparam int IEN_W   = 4;
  localparam int IEN_ERR = 0;
  localparam int IEN_RSM = 1;
  localparam int IEN_IOC = 2;
  localparam int IEN_SPD = 3;

  localparam int PSC_CONN = 0;
  localparam int PSC_RST  = 9;
  localparam logic [DATA_W-1:0] PSC_WMASK = 16'h1204;
  localparam logic [DATA_W-1:0] PSC_ONES  = 16'h0080;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_wr_t;
endpackage

// File: rtl/usbhc_ctrl.sv
module usbhc_ctrl
  import usbhc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_wr_t          bw,
  input  logic             evt_ioc,
  input  logic             evt_short,
  input  logic             evt_err,
  input  logic             resume_req,
  output logic [CMD_W-1:0] cmd_o,
  output logic [DATA_W-1:0] sts_o,
  output logic [IEN_W-1:0] ien_o,
  output logic [1:0]       cause_o,
  output logic             irq_o,
  output logic             run_o,
  output logic             halted_o,
  output logic             sched_start_o,
  output logic             bus_reset_o
);
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [IEN_W-1:0] ien_q, ien_d;
  logic [1:0]       cause_q, cause_d;
  logic int_q, int_d, err_q, err_d, rsm_q, rsm_d, halt_q, halt_d;
  logic sched_q, sched_d, grst_q, grst_d;
  logic wr_cmd, wr_sts, wr_ien, resume_ok;

  always_comb begin
    wr_cmd    = bw.wr && (bw.addr == OFF_CMD);
    wr_sts    = bw.wr && (bw.addr == OFF_STS);
    wr_ien    = bw.wr && (bw.addr == OFF_IEN);
    resume_ok = resume_req && cmd_q[CMD_EGSM];

    cmd_d = cmd_q;
    if (wr_cmd) cmd_d = bw.data[CMD_W-1:0];
    if (resume_ok) cmd_d[CMD_FGR] = 1'b1;

    halt_d = halt_q;
    if (wr_cmd) halt_d = ~bw.data[CMD_RUN];

    ien_d = ien_q;
    if (wr_ien) ien_d = bw.data[IEN_W-1:0];

    int_d   = int_q;
    err_d   = err_q;
    rsm_d   = rsm_q;
    cause_d = cause_q;
    if (wr_sts) begin
      if (bw.data[STS_INT]) begin
        int_d   = 1'b0;
        cause_d = 2'b00;
      end
      if (bw.data[STS_ERR]) err_d = 1'b0;
      if (bw.data[STS_RSM]) rsm_d = 1'b0;
    end
    if (evt_ioc) begin
      int_d      = 1'b1;
      cause_d[0] = 1'b1;
    end
    if (evt_short) begin
      int_d      = 1'b1;
      cause_d[1] = 1'b1;
    end
    if (evt_err)   err_d = 1'b1;
    if (resume_ok) rsm_d = 1'b1;

    sched_d = wr_cmd && bw.data[CMD_RUN]  && !cmd_q[CMD_RUN];
    grst_d  = wr_cmd && bw.data[CMD_GRST] && !cmd_q[CMD_GRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ien_q   <= '0;
      cause_q <= '0;
      int_q   <= 1'b0;
      err_q   <= 1'b0;
      rsm_q   <= 1'b0;
      halt_q  <= 1'b1;
      sched_q <= 1'b0;
      grst_q  <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      ien_q   <= ien_d;
      cause_q <= cause_d;
      int_q   <= int_d;
      err_q   <= err_d;
      rsm_q   <= rsm_d;
      halt_q  <= halt_d;
      sched_q <= sched_d;
      grst_q  <= grst_d;
    end
  end

  always_comb begin
    sts_o           = '0;
    sts_o[STS_INT]  = int_q;
    sts_o[STS_ERR]  = err_q;
    sts_o[STS_RSM]  = rsm_q;
    sts_o[STS_HALT] = halt_q;
    irq_o = (int_q && ((cause_q[0] && ien_q[IEN_IOC]) || (cause_q[1] && ien_q[IEN_SPD])))
         || (err_q && ien_q[IEN_ERR])
         || (rsm_q && ien_q[IEN_RSM]);
  end

  assign cmd_o         = cmd_q;
  assign ien_o         = ien_q;
  assign cause_o       = cause_q;
  assign run_o         = cmd_q[CMD_RUN];
  assign halted_o      = halt_q;
  assign sched_start_o = sched_q;
  assign bus_reset_o   = grst_q;

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && bw.data[STS_INT] && !evt_ioc && !evt_short) |=> (!sts_o[STS_INT] && cause_o == 2'b00));
  assert_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sts_o[STS_INT] || sts_o[STS_ERR] || sts_o[STS_RSM]));
  assert_sched_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sched_start_o |=> !sched_start_o);
  assert_grst_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_o |=> !bus_reset_o);
  assert_resume_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && cmd_o[CMD_EGSM]) |=> (cmd_o[CMD_FGR] && sts_o[STS_RSM]));
endmodule

// File: rtl/usbhc_frame.sv
module usbhc_frame
  import usbhc_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int SOF_W   = 8,
  parameter int SOF_RST = 64,
  parameter int BASE_W  = 32,
  parameter int BASE_Z  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bus_wr_t            bw,
  input  logic               run,
  input  logic               halted,
  input  logic               tick,
  output logic [FRAME_W-1:0] frnum_o,
  output logic [BASE_W-1:0]  base_o,
  output logic [SOF_W-1:0]   sof_o
);
  localparam int HALF = BASE_W / 2;
  localparam logic [HALF-1:0] LO_MASK = ~((HALF)'((1 << BASE_Z) - 1));

  logic [FRAME_W-1:0] frn_q, frn_d;
  logic [BASE_W-1:0]  base_q, base_d;
  logic [SOF_W-1:0]   sof_q, sof_d;
  logic wr_frn;

  always_comb begin
    wr_frn = bw.wr && (bw.addr == OFF_FRN);
    frn_d  = frn_q;
    if (tick && run) frn_d = frn_q + 1'b1;
    if (wr_frn && halted) frn_d = bw.data[FRAME_W-1:0];

    base_d = base_q;
    if (bw.wr && bw.addr == OFF_BLO) base_d[HALF-1:0]      = bw.data[HALF-1:0] & LO_MASK;
    if (bw.wr && bw.addr == OFF_BHI) base_d[BASE_W-1:HALF] = bw.data[HALF-1:0];

    sof_d = sof_q;
    if (bw.wr && bw.addr == OFF_SOF) sof_d = bw.data[SOF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frn_q  <= '0;
      base_q <= '0;
      sof_q  <= SOF_W'(SOF_RST);
    end else begin
      frn_q  <= frn_d;
      base_q <= base_d;
      sof_q  <= sof_d;
    end
  end

  assign frnum_o = frn_q;
  assign base_o  = base_q;
  assign sof_o   = sof_q;

  assert_frn_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !wr_frn) |=> (frnum_o == FRAME_W'($past(frnum_o) + 1'b1)));
  assert_frn_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_frn && !halted && !(tick && run)) |=> $stable(frnum_o));
endmodule

// File: rtl/usbhc_port.sv
module usbhc_port
  import usbhc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OFFSET = 5'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_wr_t           bw,
  input  logic              attached,
  output logic [DATA_W-1:0] rd_o,
  output logic              prst_o
);
  logic [DATA_W-1:0] psc_q, psc_d;
  logic prst_q, prst_d, hit;

  always_comb begin
    hit    = bw.wr && (bw.addr == OFFSET);
    psc_d  = psc_q;
    if (hit) psc_d = bw.data & PSC_WMASK;
    prst_d = hit && bw.data[PSC_RST] && !psc_q[PSC_RST] && attached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      prst_q <= 1'b0;
    end else begin
      psc_q  <= psc_d;
      prst_q <= prst_d;
    end
  end

  always_comb begin
    rd_o           = psc_q | PSC_ONES;
    rd_o[PSC_CONN] = attached;
  end
  assign prst_o = prst_q;

  assert_prst_dev_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |-> $past(attached));
  assert_prst_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |=> !prst_o);
endmodule

// File: rtl/usb_hc_regs.sv
module usb_hc_regs
  import usbhc_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int FRAME_W = 11,
  parameter int SOF_W   = 8,
  parameter int SOF_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic              frame_tick,
  input  logic              evt_ioc,
  input  logic              evt_short,
  input  logic              evt_err,
  input  logic              resume_req,
  input  logic [3:0]        dev_attached,
  output logic              irq,
  output logic [1:0]        int_cause,
  output logic              sched_start,
  output logic              bus_reset,
  output logic [3:0]        port_reset
);
  localparam int BASE_W = 32;
  localparam int HALF   = BASE_W / 2;

  bus_wr_t           bw;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] sts;
  logic [IEN_W-1:0]  ien;
  logic              run, halted;
  logic [FRAME_W-1:0] frnum;
  logic [BASE_W-1:0] base;
  logic [SOF_W-1:0]  sof;
  logic [DATA_W-1:0] port_rd [NPORTS];
  logic [NPORTS-1:0] port_pulse;

  assign bw = '{wr: wr_en, addr: addr, data: wdata};

  usbhc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .bw(bw),
    .evt_ioc(evt_ioc), .evt_short(evt_short), .evt_err(evt_err),
    .resume_req(resume_req),
    .cmd_o(cmd), .sts_o(sts), .ien_o(ien), .cause_o(int_cause), .irq_o(irq),
    .run_o(run), .halted_o(halted),
    .sched_start_o(sched_start), .bus_reset_o(bus_reset)
  );

  usbhc_frame #(
    .FRAME_W(FRAME_W), .SOF_W(SOF_W), .SOF_RST(SOF_RST), .BASE_W(BASE_W), .BASE_Z(12)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .bw(bw), .run(run), .halted(halted),
    .tick(frame_tick), .frnum_o(frnum), .base_o(base), .sof_o(sof)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    usbhc_port #(.OFFSET(ADDR_W'(OFF_PORT0 + 2*g))) u_port (
      .clk(clk), .rst_n(rst_n), .bw(bw), .attached(dev_attached[g]),
      .rd_o(port_rd[g]), .prst_o(port_pulse[g])
    );
  end

  assign port_reset = port_pulse | {NPORTS{bus_reset}};

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CMD: rdata = DATA_W'(cmd);
      OFF_STS: rdata = sts;
      OFF_IEN: rdata = DATA_W'(ien);
      OFF_FRN: rdata = DATA_W'(frnum);
      OFF_BLO: rdata = base[HALF-1:0];
      OFF_BHI: rdata = base[BASE_W-1:HALF];
      OFF_SOF: rdata = DATA_W'(sof);
      default: begin
        for (int i = 0; i < NPORTS; i++)
          if (addr == ADDR_W'(OFF_PORT0 + 2*i)) rdata = port_rd[i];
      end
    endcase
  end

  assert_gport_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> (port_reset == {NPORTS{1'b1}}));
endmodule

// File: tb/sim_usb_hc_regs.sv
module sim_usb_hc_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic frame_tick = 1'b0, evt_ioc = 1'b0, evt_short = 1'b0, evt_err = 1'b0, resume_req = 1'b0;
  logic [3:0] dev_attached = 4'b0010;
  logic irq, sched_start, bus_reset;
  logic [1:0] int_cause;
  logic [3:0] port_reset;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  usb_hc_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .frame_tick(frame_tick), .evt_ioc(evt_ioc), .evt_short(evt_short), .evt_err(evt_err),
    .resume_req(resume_req), .dev_attached(dev_attached), .irq(irq), .int_cause(int_cause),
    .sched_start(sched_start), .bus_reset(bus_reset), .port_reset(port_reset)
  );

  // {write, offset, write data, expected read}
  localparam int NV = 11;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 5'h0C, 16'h1234, 16'h0034},  // R8
    {1'b1, 5'h08, 16'hABCD, 16'hA000},  // R7
    {1'b1, 5'h0A, 16'h5678, 16'h5678},  // R7
    {1'b0, 5'h08, 16'h0000, 16'hA000},  // R7
    {1'b1, 5'h06, 16'hFFFF, 16'h07FF},  // R5
    {1'b1, 5'h04, 16'h00FF, 16'h000F},  // R2
    {1'b1, 5'h0E, 16'hFFFF, 16'h0000},  // R2
    {1'b1, 5'h18, 16'hFFFF, 16'h0000},  // R2
    {1'b1, 5'h12, 16'h0004, 16'h0085},  // R10
    {1'b0, 5'h1E, 16'h0000, 16'h0000},  // R2
    {1'b1, 5'h04, 16'h0000, 16'h0000}   // R2
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_in(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, v); check("R1 cmd", v, 16'h0000);
    rd(5'h02, v); check("R1 sts", v, 16'h0020);
    rd(5'h06, v); check("R1 frnum", v, 16'h0000);
    rd(5'h0A, v); check("R1 base hi", v, 16'h0000);
    rd(5'h0C, v); check("R1 sof", v, 16'h0040);
    rd(5'h10, v); check("R1 port0", v, 16'h0080);
    rd(5'h12, v); check("R1 port1", v, 16'h0081);
    check("R1 outs", {11'd0, irq, int_cause, sched_start, bus_reset}, 16'h0000);
    check("R1 port_reset", {12'd0, port_reset}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) wr(VEC[i][36:32], VEC[i][31:16]);
      rd(VEC[i][36:32], v);
      check($sformatf("R2 vector %0d", i), v, VEC[i][15:0]);
    end

    // R9 start of scheduling
    wr(5'h00, 16'h0001);
    check("R9 sched pulse", {15'd0, sched_start}, 16'h0001);
    rd(5'h02, v); check("R9 halted clear", v, 16'h0000);
    @(negedge clk);
    check("R9 pulse one cycle", {15'd0, sched_start}, 16'h0000);
    wr(5'h00, 16'h0001);
    check("R9 no repeat pulse", {15'd0, sched_start}, 16'h0000);

    // R6 frame count and wrap (frame number is 0x7FF)
    pulse_in(frame_tick);
    rd(5'h06, v); check("R6 wrap", v, 16'h0000);
    pulse_in(frame_tick);
    rd(5'h06, v); check("R6 inc", v, 16'h0001);
    // R5 write while running ignored
    wr(5'h06, 16'h0100);
    rd(5'h06, v); check("R5 locked", v, 16'h0001);

    // R3/R4 status and interrupt
    pulse_in(evt_ioc);
    rd(5'h02, v); check("R3 usbint set", v, 16'h0001);
    check("R3 cause ioc", {14'd0, int_cause}, 16'h0001);
    check("R4 irq masked", {15'd0, irq}, 16'h0000);
    wr(5'h04, 16'h0004);
    check("R4 irq ioc", {15'd0, irq}, 16'h0001);
    wr(5'h04, 16'h0008);
    check("R4 irq spd only", {15'd0, irq}, 16'h0000);
    pulse_in(evt_short);
    check("R3 cause both", {14'd0, int_cause}, 16'h0003);
    check("R4 irq spd", {15'd0, irq}, 16'h0001);
    wr(5'h02, 16'h0001);
    rd(5'h02, v); check("R3 w1c", v, 16'h0000);
    check("R3 cause cleared", {14'd0, int_cause}, 16'h0000);
    check("R4 irq low", {15'd0, irq}, 16'h0000);
    pulse_in(evt_err);
    wr(5'h04, 16'h0001);
    check("R4 irq err", {15'd0, irq}, 16'h0001);
    wr(5'h02, 16'h0004);
    rd(5'h02, v); check("R3 other bits kept", v, 16'h0002);
    wr(5'h02, 16'h0002);
    rd(5'h02, v); check("R3 err clear", v, 16'h0000);
    wr(5'h04, 16'h0000);

    // R12 resume
    pulse_in(resume_req);
    rd(5'h00, v); check("R12 no suspend cmd", v, 16'h0001);
    rd(5'h02, v); check("R12 no suspend sts", v, 16'h0000);
    wr(5'h00, 16'h0009);
    pulse_in(resume_req);
    rd(5'h00, v); check("R12 fgr", v, 16'h0019);
    rd(5'h02, v); check("R12 rsm", v, 16'h0004);
    wr(5'h02, 16'h0004);

    // R10 port reset
    wr(5'h12, 16'h0200);
    check("R10 port1 pulse", {12'd0, port_reset}, 16'h0002);
    rd(5'h12, v); check("R10 port1 read", v, 16'h0281);
    @(negedge clk);
    check("R10 pulse one cycle", {12'd0, port_reset}, 16'h0000);
    wr(5'h10, 16'h0200);
    check("R10 detached no pulse", {12'd0, port_reset}, 16'h0000);

    // R11 global reset
    wr(5'h00, 16'h0004);
    check("R11 bus_reset", {15'd0, bus_reset}, 16'h0001);
    check("R11 all ports", {12'd0, port_reset}, 16'h000F);
    rd(5'h02, v); check("R9 halted set", v, 16'h0020);
    @(negedge clk);
    check("R11 one cycle", {11'd0, bus_reset, port_reset}, 16'h0000);
    wr(5'h00, 16'h0000);

    // R5 frame write while halted
    wr(5'h06, 16'hF123);
    rd(5'h06, v); check("R5 halted write", v, 16'h0123);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule